// File: doc/BRIEF.md
# Divide-by-three clock divider with balanced duty cycle

This block takes an input clock and produces a clock at one third of its frequency whose high and low phases are equal, each lasting one and a half input periods. An odd ratio with a balanced duty cycle cannot be built from rising-edge logic alone. The block therefore uses both edges of the input clock.

Two flops clocked on the rising edge form a three-state counter. A single NOR gate closes the counter loop. The loop has no trap state, so an upset lands back in the sequence within two rising edges. One flop clocked on the falling edge holds a copy of the counter's low bit, delayed by half an input period. An OR of the low bit and its delayed copy forms the output. At every output transition, only one of the two OR inputs changes, so the output cannot glitch.

The reset is active low and asynchronous. It is expected to be released synchronously upstream, between a falling and the next rising edge of the input clock.

Top module: `clkdiv3_duty50`

## Requirements
- R1: While rst_n is low, clk_out is low. After rst_n is released between a falling and a rising edge of clk_in, clk_out stays low until that next rising edge.
- R2: Just after the first rising edge of clk_in that follows reset release, clk_out is high.
- R3: Every high phase of clk_out lasts exactly three half-periods of clk_in.
- R4: Every low phase of clk_out lasts exactly three half-periods of clk_in, so the output period is three input periods.
- R5: clk_out makes at most one transition per half-period of clk_in, and it never pulses between input edges.
- R6: The counter state is written as the pair (high bit, low bit). If the counter is put into the unused state with both bits at 1, it returns to the normal sequence. Measured from the second rising edge after the upset, clk_out goes low for two half-periods, then high for three half-periods, then it continues with the normal 3/3 pattern.
- R7: In normal running, clk_out rises only just after a rising edge of clk_in and falls only just after a falling edge.
- R8: Asserting rst_n low at any instant, even between clock edges, drives clk_out low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_out | output | 1 | Divided clock at one third of clk_in, 50% duty |

## Verification
Four properties are checked on every edge of the input clock:
- The counter's low bit is never high on two rising edges in a row, and after it falls it stays low for another edge.
- The unused counter state always leads to the state that re-enters the sequence.
- The falling-edge flop always holds the low bit as sampled at the previous falling edge.
- Sampled on rising edges, the output shows a single high sample followed by at least two low ones.

Only the bench scenarios can show the exact half-period lengths of each phase. The same holds for the absence of extra transitions between clock edges and the immediate effect of a reset asserted mid-cycle. These also cover recovery from a forced upset of the counter, observed at the output pin.

// File: rtl/clkdiv3_pkg.sv
package clkdiv3_pkg;
  localparam int unsigned CNT_W = 2;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_RESET   = cnt_t'(0);
  localparam cnt_t CNT_UNUSED  = cnt_t'(3);
  localparam cnt_t CNT_REENTRY = cnt_t'(2);
endpackage

// File: rtl/clkdiv3_mod3_cnt.sv
module clkdiv3_mod3_cnt
  import clkdiv3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic tap
);
  cnt_t state_q;
  cnt_t state_d;

  // next low bit is NOR of both bits, next high bit is the old low bit
  always_comb begin
    state_d = {state_q[0], ~(state_q[0] | state_q[1])};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CNT_RESET;
    else        state_q <= state_d;
  end

  assign tap = state_q[0];

  AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tap |=> !tap); // R3
  AST_TAP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tap) |=> !tap); // R4
  AST_UNUSED_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CNT_UNUSED) |=> (state_q == CNT_REENTRY)); // R6
endmodule

// File: rtl/clkdiv3_half_delay.sv
module clkdiv3_half_delay (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

  AST_HALF_COPY: assert property (@(negedge clk) disable iff (!rst_n)
    q == $past(d)); // R5
endmodule

// File: rtl/clkdiv3_merge.sv
module clkdiv3_merge (
  input  logic early,
  input  logic late,
  output logic merged
);
  assign merged = early | late;
endmodule

// File: rtl/clkdiv3_duty50.sv
module clkdiv3_duty50 (
  input  logic clk_in,
  input  logic rst_n,
  output logic clk_out
);
  logic tap_rise;
  logic tap_fall;

  clkdiv3_mod3_cnt u_count (
    .clk   (clk_in),
    .rst_n (rst_n),
    .tap   (tap_rise)
  );

  clkdiv3_half_delay u_delay (
    .clk   (clk_in),
    .rst_n (rst_n),
    .d     (tap_rise),
    .q     (tap_fall)
  );

  clkdiv3_merge u_merge (
    .early  (tap_rise),
    .late   (tap_fall),
    .merged (clk_out)
  );

  AST_OUT_PULSE: assert property (@(posedge clk_in) disable iff (!rst_n)
    clk_out |=> !clk_out); // R3
  AST_OUT_GAP: assert property (@(posedge clk_in) disable iff (!rst_n)
    $fell(clk_out) |=> !clk_out); // R4
endmodule

// File: tb/tb_clkdiv3_duty50.sv
`timescale 1ns/1ps
module tb_clkdiv3_duty50;
  logic clk_in = 1'b0;
  logic rst_n  = 1'b0;
  logic clk_out;
  int   checks = 0;
  int   errors = 0;
  int   toggles = 0;

  clkdiv3_duty50 dut (.clk_in(clk_in), .rst_n(rst_n), .clk_out(clk_out));

  always #2 clk_in = ~clk_in;
  always @(clk_out) toggles++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_wave(input int k, input int lead);
    if (k < lead) return 0;
    return (((k - lead) % 6) < 3) ? 1 : 0;
  endfunction

  task automatic release_reset();
    @(negedge clk_in);
    #1 rst_n = 1'b1;
    #0.5 check(clk_out == 1'b0, "R1 low after release", int'(clk_out), 0);
  endtask

  task automatic run_window(input int nhalf, input int lead);
    logic prev;
    logic cur;
    bit   was_rise;
    prev = clk_out;
    toggles = 0;
    for (int k = 0; k < nhalf; k++) begin
      @(clk_in);
      was_rise = clk_in;
      #1 cur = clk_out;
      if (k < lead)
        check(int'(cur) == exp_wave(k, lead), "R6 recovery", int'(cur), exp_wave(k, lead));
      else if (k == 0)
        check(int'(cur) == exp_wave(k, lead), "R2 first high", int'(cur), exp_wave(k, lead));
      else if (exp_wave(k, lead) == 1)
        check(cur == 1'b1, "R3 high phase", int'(cur), 1);
      else
        check(cur == 1'b0, "R4 low phase", int'(cur), 0);
      check(toggles == ((cur != prev) ? 1 : 0), "R5 transitions", toggles, (cur != prev) ? 1 : 0);
      if (k >= lead && cur != prev)
        check(cur == was_rise, "R7 edge direction", int'(cur), int'(was_rise));
      prev = cur;
      toggles = 0;
    end
  endtask

  task automatic async_reset(input int offset_tenths);
    #(offset_tenths * 0.1);
    rst_n = 1'b0;
    #0.2 check(clk_out == 1'b0, "R8 async clear", int'(clk_out), 0);
    repeat (2) @(posedge clk_in);
    #1 check(clk_out == 1'b0, "R1 held in reset", int'(clk_out), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_in);
    #1 check(clk_out == 1'b0, "R1 reset state", int'(clk_out), 0);
    release_reset();
    run_window(60, 0);
    for (int i = 0; i < 20; i++) begin
      async_reset(int'($urandom % 40));
      release_reset();
      run_window(12 + int'($urandom % 60), 0);
    end
    async_reset(7);
    release_reset();
    force dut.u_count.state_q = 2'b11;
    #0.2 release dut.u_count.state_q;
    run_window(48, 4);
    async_reset(0);
    release_reset();
    run_window(24, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule